// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Sequencer

This block sits between a simple host request port and an asynchronous DRAM whose row and column addresses share one address bus. Every host request carries a flat address. The top field picks one of several DRAM chips, the middle field is the row, and the low field is the column. For a closed page the block drives the row and lowers RAS#. It waits a programmable number of cycles, then drives the column and lowers CAS#. The row stays open afterwards. A later request to the same chip and row gets only a new CAS# pulse. A request to another chip or another row first closes the page with a precharge period, then runs the full sequence.

A refresh interval counter raises a refresh request at a programmable period. Once the access in flight completes, the refresh takes priority over new host requests. Any open row is precharged first. A refresh row from an internal counter is then strobed on all chips with CAS# held high, and the counter advances. If the open page sees no request for a programmable number of cycles, the block closes it.

The states are IDLE (no row open), RAS_WAIT (row strobed, counting the RAS-to-CAS delay), CAS_ACT (column strobed), ROW_OPEN (page held, waiting), PRECHARGE (RAS# high, counting the precharge time) and REF_RAS (refresh row strobed). The transitions are:
- IDLE→REF_RAS on a pending refresh, and IDLE→RAS_WAIT on an accepted request.
- RAS_WAIT→CAS_ACT when the delay expires, and CAS_ACT→ROW_OPEN at the end of the CAS pulse.
- ROW_OPEN→CAS_ACT on a page hit.
- ROW_OPEN→PRECHARGE on a page miss, a pending refresh or the idle timeout.
- PRECHARGE→RAS_WAIT when a miss is waiting. Otherwise PRECHARGE→REF_RAS when a refresh is pending, and PRECHARGE→IDLE in any other case.
- REF_RAS→PRECHARGE when the refresh pulse ends.

Top module: `pgdram_ctrl`

## Requirements
- R1: Address bits [23:20] select the chip, and the chosen chip's `dram_cs_n` bit is the only low bit during an access. Bits [19:10] are the row and bits [9:0] the column.
- R2: On a closed page, `dram_addr` carries the row when RAS# falls and the column when CAS# falls. CAS# is never low while RAS# is high.
- R3: CAS# falls exactly `cfg_rcd` cycles after RAS# falls. A setting of 0 acts as 1.
- R4: CAS# stays low for CAS_CYC cycles (default 2). For a read, `rd_valid` pulses for one cycle in the first cycle after CAS# rises. `rd_data` then holds `dram_dq_in` as sampled on the last CAS# cycle.
- R5: `dram_we_n` is low, and `dram_dq_oe` is high with the write data on `dram_dq_out`, only during the CAS# cycles of a write.
- R6: A request to the open chip and row produces a CAS# pulse with no new RAS# fall.
- R7: A request to a different row or chip raises RAS# for exactly `cfg_rp` cycles before the new row's RAS# fall. A setting of 0 acts as 1.
- R8: With `cfg_refi` nonzero, a refresh is requested every `cfg_refi` cycles. A refresh lowers RAS# on all chips with CAS# high for `cfg_rcd` cycles. It drives the refresh row, which starts at 0 after reset and increments by one per refresh, and it is followed by a precharge. When `cfg_refi` is 0, refresh is disabled.
- R9: While a refresh is pending, `req_ready` is low, and an open row is precharged before the refresh RAS# fall.
- R10: An open page that receives no request closes: RAS# rises `cfg_idle` cycles after the end of the last CAS# pulse.
- R11: After reset, RAS#, CAS#, WE# and every chip select are high, `req_ready` is high, and `rd_valid` and `dram_dq_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat address {chip, row, column} |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| cfg_rcd | input | 8 | RAS-to-CAS delay in cycles (also refresh RAS width) |
| cfg_rp | input | 8 | Precharge time in cycles |
| cfg_idle | input | 8 | Open-page idle limit in cycles |
| cfg_refi | input | 12 | Refresh period in cycles, 0 = off |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_cs_n | output | 16 | Active-low chip selects |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
The assertions check the strobe rules on every cycle. These rules are that CAS# falls only with RAS# already low, WE# and the data enable appear only inside a CAS# pulse, the read-valid pulse is one cycle long, and ready stays low while a refresh is pending. They also check one chip select at a time outside refresh, and the immediate RAS# behaviour after a page hit or miss. Only the bench scenarios can show the exact cycle counts of the RAS-to-CAS, precharge, CAS width and idle-close windows across a sweep of settings. The same holds for the row and column values at each strobe edge, the read data path, and the order and row values of refreshes.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAS_WAIT,
        ST_CAS_ACT,
        ST_ROW_OPEN,
        ST_PRECHARGE,
        ST_REF_RAS
    } pg_state_e;

endpackage

// File: rtl/pgdram_addr_split.sv
module pgdram_addr_split #(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 10,
    localparam int CS_W  = ADDR_W - ROW_W - COL_W,
    localparam int NCS   = 1 << CS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CS_W-1:0]   cs_idx,
    output logic [NCS-1:0]    cs_onehot,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    assign col    = addr[COL_W-1:0];
    assign row    = addr[COL_W +: ROW_W];
    assign cs_idx = addr[ADDR_W-1 -: CS_W];

    for (genvar g = 0; g < NCS; g++) begin : g_dec
        assign cs_onehot[g] = (cs_idx == CS_W'(g));
    end

endmodule

// File: rtl/pgdram_step_timer.sv
module pgdram_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pgdram_refresh_gen.sv
module pgdram_refresh_gen #(
    parameter int REF_W = 12,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] cfg_refi,
    input  logic             ref_ack,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);

    logic [REF_W-1:0] tick;
    logic             hit_period;

    assign hit_period = (cfg_refi != '0) && (tick >= cfg_refi - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick     <= '0;
            ref_pend <= 1'b0;
        end else begin
            if (cfg_refi == '0)  tick <= '0;
            else if (hit_period) tick <= '0;
            else                 tick <= tick + 1'b1;

            if (hit_period)   ref_pend <= 1'b1;
            else if (ref_ack) ref_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_row <= '0;
        else if (ref_ack) ref_row <= ref_row + 1'b1;
    end

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
    import pgdram_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int ROW_W   = 10,
    parameter int COL_W   = 10,
    parameter int DATA_W  = 8,
    parameter int TMR_W   = 8,
    parameter int REF_W   = 12,
    parameter int CAS_CYC = 2,
    localparam int CS_W   = ADDR_W - ROW_W - COL_W,
    localparam int NCS    = 1 << CS_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [TMR_W-1:0]  cfg_rcd,
    input  logic [TMR_W-1:0]  cfg_rp,
    input  logic [TMR_W-1:0]  cfg_idle,
    input  logic [REF_W-1:0]  cfg_refi,
    output logic [MA_W-1:0]   dram_addr,
    output logic [NCS-1:0]    dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);

    pg_state_e state, state_d;

    // Incoming address fields
    logic [CS_W-1:0]  in_cs;
    logic [NCS-1:0]   in_oh;
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;

    pgdram_addr_split #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(req_addr), .cs_idx(in_cs), .cs_onehot(in_oh), .row(in_row), .col(in_col)
    );

    // Latched request (also the open page while a row is held)
    logic [CS_W-1:0]   q_cs;
    logic [NCS-1:0]    q_oh;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic              q_we;
    logic [DATA_W-1:0] q_wdata;
    logic              pend_acc;

    logic accept, page_hit;
    assign req_ready = ((state == ST_IDLE) || (state == ST_ROW_OPEN)) && !ref_pend;
    assign accept    = req_valid && req_ready;
    assign page_hit  = (in_cs == q_cs) && (in_row == q_row);

    logic [NCS-1:0]    nx_oh;
    logic [ROW_W-1:0]  nx_row;
    logic [COL_W-1:0]  nx_col;
    logic              nx_we;
    logic [DATA_W-1:0] nx_wdata;
    assign nx_oh    = accept ? in_oh     : q_oh;
    assign nx_row   = accept ? in_row    : q_row;
    assign nx_col   = accept ? in_col    : q_col;
    assign nx_we    = accept ? req_we    : q_we;
    assign nx_wdata = accept ? req_wdata : q_wdata;

    // Refresh interval and row counter
    logic             ref_pend, ref_ack;
    logic [ROW_W-1:0] ref_row;
    assign ref_ack = (state_d == ST_REF_RAS) && (state != ST_REF_RAS);

    pgdram_refresh_gen #(.REF_W(REF_W), .ROW_W(ROW_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .cfg_refi(cfg_refi), .ref_ack(ref_ack),
        .ref_pend(ref_pend), .ref_row(ref_row)
    );

    // Shared phase timer: loaded with N-1 on state entry, N cycles in state
    function automatic logic [TMR_W-1:0] cyc_m1(input logic [TMR_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    logic             tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_val;
    assign tmr_load = (state_d != state);

    always_comb begin
        unique case (state_d)
            ST_RAS_WAIT:  tmr_val = cyc_m1(cfg_rcd);
            ST_CAS_ACT:   tmr_val = TMR_W'(CAS_CYC - 1);
            ST_ROW_OPEN:  tmr_val = cyc_m1(cfg_idle);
            ST_PRECHARGE: tmr_val = cyc_m1(cfg_rp);
            ST_REF_RAS:   tmr_val = cyc_m1(cfg_rcd);
            default:      tmr_val = '0;
        endcase
    end

    pgdram_step_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend)    state_d = ST_REF_RAS;
                else if (accept) state_d = ST_RAS_WAIT;
            end
            ST_RAS_WAIT: if (tmr_done) state_d = ST_CAS_ACT;
            ST_CAS_ACT:  if (tmr_done) state_d = ST_ROW_OPEN;
            ST_ROW_OPEN: begin
                if (ref_pend)      state_d = ST_PRECHARGE;
                else if (accept)   state_d = page_hit ? ST_CAS_ACT : ST_PRECHARGE;
                else if (tmr_done) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                if (tmr_done) begin
                    if (pend_acc)      state_d = ST_RAS_WAIT;
                    else if (ref_pend) state_d = ST_REF_RAS;
                    else               state_d = ST_IDLE;
                end
            end
            ST_REF_RAS: if (tmr_done) state_d = ST_PRECHARGE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Request latch and deferred-miss flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_cs <= '0; q_oh <= '0; q_row <= '0; q_col <= '0;
            q_we <= 1'b0; q_wdata <= '0; pend_acc <= 1'b0;
        end else begin
            if (accept) begin
                q_cs <= in_cs; q_oh <= in_oh; q_row <= in_row; q_col <= in_col;
                q_we <= req_we; q_wdata <= req_wdata;
            end
            if (state == ST_ROW_OPEN && accept && !page_hit) pend_acc <= 1'b1;
            else if (state_d == ST_RAS_WAIT)                 pend_acc <= 1'b0;
        end
    end

    // Registered DRAM-side outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_ras_n  <= 1'b1;
            dram_cas_n  <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_cs_n   <= '1;
            dram_addr   <= '0;
            dram_dq_out <= '0;
            dram_dq_oe  <= 1'b0;
        end else begin
            dram_ras_n  <= !(state_d inside {ST_RAS_WAIT, ST_CAS_ACT, ST_ROW_OPEN, ST_REF_RAS});
            dram_cas_n  <= (state_d != ST_CAS_ACT);
            dram_we_n   <= !((state_d == ST_CAS_ACT) && nx_we);
            dram_dq_oe  <= (state_d == ST_CAS_ACT) && nx_we;
            dram_dq_out <= nx_wdata;
            unique case (state_d)
                ST_RAS_WAIT: begin dram_addr <= MA_W'(nx_row); dram_cs_n <= ~nx_oh; end
                ST_CAS_ACT:  begin dram_addr <= MA_W'(nx_col); dram_cs_n <= ~nx_oh; end
                ST_ROW_OPEN: dram_cs_n <= ~nx_oh;
                ST_REF_RAS:  begin dram_addr <= MA_W'(ref_row); dram_cs_n <= '0; end
                default:     dram_cs_n <= '1;
            endcase
        end
    end

    // Read capture on the last CAS cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_CAS_ACT) && tmr_done && !q_we;
            if ((state == ST_CAS_ACT) && tmr_done && !q_we) rd_data <= dram_dq_in;
        end
    end

    // Assertions
    assert_cas_under_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    assert_cas_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $past(!dram_ras_n));
    assert_rdv_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    assert_we_in_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_we_n || dram_dq_oe) |-> !dram_cas_n);
    assert_hit_no_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_OPEN && accept && page_hit) |=> (!dram_ras_n && !dram_cas_n));
    assert_miss_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_OPEN && accept && !page_hit) |=> dram_ras_n);
    assert_ready_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
    assert_single_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_REF_RAS) |-> $onehot0(~dram_cs_n));

endmodule

// File: tb/test_pgdram_ctrl.sv
module test_pgdram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  cfg_rcd = 8'd2, cfg_rp = 8'd2, cfg_idle = 8'd40;
    logic [11:0] cfg_refi = '0;
    logic [9:0]  dram_addr;
    logic [15:0] dram_cs_n;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [7:0]  dram_dq_out, dram_dq_in;

    localparam int CASW = 2;

    always #10 clk = ~clk;

    pgdram_ctrl i_pgdram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_rcd(cfg_rcd), .cfg_rp(cfg_rp), .cfg_idle(cfg_idle), .cfg_refi(cfg_refi),
        .dram_addr(dram_addr), .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cs_of(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (!v[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] mdl(input int cs, input int row, input int col);
        return 8'(row * 3 + col * 5 + cs * 17);
    endfunction

    // Bus monitor, updated at each falling clock edge
    int cyc = 0;
    int ras_lo = 0, ras_hi = 0, cas_lo = 0;
    int ras_falls = 0, cas_falls = 0;
    int last_rcd = 0, last_rp = 0, last_row = 0, last_col = 0, last_caslen = 0;
    int cas_rise_cyc = 0, ras_rise_cyc = 0;
    int mdl_row = 0;
    int ref_cnt = 0, ref_first_row = -1, ref_prev_row = 0, ref_bad = 0;
    int ref_rp_min = 1000, ref_ras_len = 0, ready_at_ref = 0;
    int bad_we = 0;
    bit ras_prev = 1'b1, cas_prev = 1'b1, last_fall_ref = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!dram_ras_n) begin
                if (ras_prev) begin
                    ras_falls++;
                    last_rp  = ras_hi;
                    last_row = int'(dram_addr);
                    mdl_row  = int'(dram_addr);
                    last_fall_ref = (dram_cs_n == 16'h0000) && dram_cas_n;
                    if (last_fall_ref) begin
                        if (ref_cnt == 0) ref_first_row = int'(dram_addr);
                        else if (int'(dram_addr) != ref_prev_row + 1) ref_bad++;
                        ref_prev_row = int'(dram_addr);
                        ref_cnt++;
                        if (ras_hi < ref_rp_min) ref_rp_min = ras_hi;
                        if (req_ready) ready_at_ref++;
                    end
                    ras_lo = 1;
                end else ras_lo++;
            end else begin
                if (!ras_prev) begin
                    ras_rise_cyc = cyc;
                    if (last_fall_ref) ref_ras_len = ras_lo;
                    ras_hi = 1;
                end else ras_hi++;
            end
            if (!dram_cas_n) begin
                if (cas_prev) begin
                    cas_falls++;
                    last_rcd = ras_lo - 1;
                    last_col = int'(dram_addr);
                    cas_lo = 1;
                end else cas_lo++;
            end else if (!cas_prev) begin
                cas_rise_cyc = cyc;
                last_caslen  = cas_lo;
            end
            if (!dram_we_n && dram_cas_n) bad_we++;
            ras_prev = dram_ras_n;
            cas_prev = dram_cas_n;
        end
    end

    // DRAM data model: value derived from chip, row and column
    assign dram_dq_in = dram_cas_n ? 8'h00 : mdl(cs_of(dram_cs_n), mdl_row, int'(dram_addr));

    task automatic step;
        @(negedge clk); #1;
    endtask

    // kind: 0 = closed page, 1 = page hit, 2 = page miss
    task automatic access(input int cs, input int row, input int col, input bit we,
                          input logic [7:0] wd, input int kind);
        int rf0, cf0, to;
        rf0 = ras_falls; cf0 = cas_falls;
        req_addr  = {4'(cs), 10'(row), 10'(col)};
        req_we    = we;
        req_wdata = wd;
        req_valid = 1'b1;
        to = 0;
        while (!req_ready && to < 300) begin step(); to++; end
        step();
        req_valid = 1'b0;
        to = 0;
        while (cas_falls == cf0 && to < 300) begin step(); to++; end
        chk(to < 300, "R2", "CAS fall seen", to, 0);
        chk(last_col == col, "R2", "column at CAS fall", last_col, col);
        chk(dram_cs_n == ~(16'h1 << cs), "R1", "chip select", int'(dram_cs_n), int'(~(16'h1 << cs) & 16'hFFFF));
        if (kind == 1) begin
            chk(ras_falls == rf0, "R6", "no RAS fall on hit", ras_falls - rf0, 0);
        end else begin
            chk(ras_falls == rf0 + 1, "R2", "one RAS fall", ras_falls - rf0, 1);
            chk(last_row == row, "R2", "row at RAS fall", last_row, row);
            chk(last_rcd == ((cfg_rcd == 0) ? 1 : int'(cfg_rcd)), "R3", "RAS-to-CAS cycles",
                last_rcd, (cfg_rcd == 0) ? 1 : int'(cfg_rcd));
        end
        if (kind == 2)
            chk(last_rp == ((cfg_rp == 0) ? 1 : int'(cfg_rp)), "R7", "precharge cycles",
                last_rp, (cfg_rp == 0) ? 1 : int'(cfg_rp));
        if (we) begin
            chk(!dram_we_n && dram_dq_oe, "R5", "write strobes", {dram_we_n, dram_dq_oe}, 1);
            chk(dram_dq_out == wd, "R5", "write data", int'(dram_dq_out), int'(wd));
        end else begin
            chk(dram_we_n && !dram_dq_oe, "R5", "read keeps WE high", {dram_we_n, dram_dq_oe}, 2);
        end
        to = 0;
        while (!dram_cas_n && to < 300) begin step(); to++; end
        chk(last_caslen == CASW, "R4", "CAS width", last_caslen, CASW);
        if (!we) begin
            chk(rd_valid == 1'b1, "R4", "rd_valid after CAS", int'(rd_valid), 1);
            chk(rd_data == mdl(cs, row, col), "R4", "read data", int'(rd_data), int'(mdl(cs, row, col)));
            step();
            chk(rd_valid == 1'b0, "R4", "rd_valid one cycle", int'(rd_valid), 0);
        end
    endtask

    // Watchdog
    initial begin
        int wd_cyc;
        wd_cyc = 0;
        forever begin
            @(posedge clk);
            wd_cyc++;
            if (wd_cyc > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog: actual %0d expected %0d", wd_cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        int combo, base, rc;
        repeat (5) @(negedge clk);
        #1;
        // R11: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R11", "strobes high in reset",
            {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        rst_n = 1'b1;
        step();
        chk(dram_cs_n == 16'hFFFF, "R11", "chip selects high", int'(dram_cs_n), 65535);
        chk(req_ready && !rd_valid && !dram_dq_oe, "R11", "ready/valid/oe",
            {req_ready, rd_valid, dram_dq_oe}, 4);

        // R3 R6 R7: sweep of delay settings
        combo = 0;
        for (int rcd = 0; rcd <= 4; rcd++) begin
            for (int rp = 0; rp <= 3; rp++) begin
                cfg_rcd = 8'(rcd);
                cfg_rp  = 8'(rp);
                cs_sel: begin end
                base = 100 + combo * 3;
                rc   = (rcd + rp * 3) & 14;
                access(rc, base, 7 + combo, 1'b0, 8'h00, (combo == 0) ? 0 : 2);
                access(rc, base, 300 + combo, 1'b0, 8'h00, 1);
                access(rc, base, 600 + combo, 1'b1, 8'(combo * 11 + 5), 1);
                access(rc, base + 1, 900 + combo, 1'b0, 8'h00, 2);
                access(rc + 1, base + 1, 1000 + combo, 1'b0, 8'h00, 2);
                combo++;
            end
        end
        chk(bad_we == 0, "R5", "WE low outside CAS", bad_we, 0);
        chk(ref_cnt == 0, "R8", "no refresh when period is 0", ref_cnt, 0);

        // R10: idle close
        cfg_rcd = 8'd3; cfg_rp = 8'd2;
        for (int idl = 3; idl <= 9; idl += 3) begin
            cfg_idle = 8'(idl);
            access(5, 20 + idl, 40, 1'b0, 8'h00, (idl == 3) ? 2 : 0);
            begin
                int to;
                to = 0;
                while (!dram_ras_n && to < 300) begin step(); to++; end
            end
            chk(ras_rise_cyc - cas_rise_cyc == idl, "R10", "idle cycles before close",
                ras_rise_cyc - cas_rise_cyc, idl);
            chk(dram_cs_n == 16'hFFFF, "R10", "chips deselected after close", int'(dram_cs_n), 65535);
        end
        access(5, 29, 41, 1'b0, 8'h00, 0);

        // R8 R9: refresh with a page held open
        cfg_idle = 8'd200;
        access(2, 77, 12, 1'b0, 8'h00, 2);
        cfg_refi = 12'd60;
        repeat (200) step();
        chk(ref_cnt >= 3 && ref_cnt <= 4, "R8", "refresh count in 200 cycles", ref_cnt, 3);
        chk(ref_first_row == 0, "R8", "first refresh row", ref_first_row, 0);
        chk(ref_bad == 0, "R8", "refresh rows increment", ref_bad, 0);
        chk(ref_ras_len == 3, "R8", "refresh RAS width", ref_ras_len, 3);
        chk(ref_rp_min >= 2, "R9", "precharge before refresh", ref_rp_min, 2);
        chk(ready_at_ref == 0, "R9", "ready low at refresh", ready_at_ref, 0);
        cfg_refi = 12'd0;
        repeat (20) step();
        begin
            int rc0;
            rc0 = ref_cnt;
            access(3, 55, 66, 1'b0, 8'h00, 0);
            repeat (150) step();
            chk(ref_cnt == rc0, "R8", "refresh stops when disabled", ref_cnt, rc0);
        end
        chk(bad_we == 0, "R5", "WE low outside CAS (final)", bad_we, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule